// File: doc/BRIEF.md
# SPI Master with Per-Select Timing Profiles

This block is an SPI master shift engine for a chip that talks to several slave devices, each with its own timing needs. Every chip-select line owns a timing profile. The profile sets a setup window from select assertion to the first data bit and a hold window from the last bit to select release. It also sets a minimum idle gap before another word may start, two delays that place an enable strobe around the data, and an optional trailing parity bit of either sense. Data moves most significant bit first in SPI mode 0. The serial clock is a division of the module clock.

Software-side logic loads a profile with a single-cycle write of a packed configuration word. It then requests a word by raising `start` with the select index, the transmit data and a flag that asks to keep the select asserted afterwards. The block raises `done` for one cycle when the word is complete, and the received data is valid on `rx_word` in that cycle. A global re-arm input forces the select to be released after every word, even when the request asked to keep it.

Top module: `spi_cs_timed_master`

## Requirements
- R1: Each select index holds its own profile, written when `cfg_we` is high. Bits [7:0] hold setup, [15:8] hold, [23:16] gap, [31:24] enable-on delay and [39:32] enable-off delay. Bit 40 disables the timers, bit 41 enables parity and bit 42 selects even parity.
- R2: After `start` is accepted, the addressed `cs_n` line goes low on the next cycle. The data phase begins max(setup, on×D) cycles later, where D is the effective divider. SCLK first rises D/2 (rounded down) cycles into the data phase.
- R3: After the last bit period, `cs_n` and `done` change after max(hold, off×D) further cycles.
- R4: When the timer-disable bit is set, setup and hold count as zero. The enable-strobe windows still apply.
- R5: `ena` is low for the first on×D cycles of the select window and then high through the data. It stays high for exactly off×D cycles after the data, and it is only ever high while a select is low.
- R6: With parity enabled, one extra bit follows the data. It is the XOR of the data bits when bit 42 is 1, and its inverse when bit 42 is 0.
- R7: Data is shifted out MSB first and changes only while SCLK is low. `miso` is sampled at each of the first DATA_W rising periods, and the assembled word appears on `rx_word` in the `done` cycle.
- R8: Each bit lasts D module cycles, where D = `clk_div`, or 2 when `clk_div` < 2. SCLK idles low and is never high while all selects are high.
- R9: After `done`, a further gap-count of cycles passes before a new `start` can be accepted.
- R10: `start` has no effect while a word, its setup or hold window, or the gap is in progress.
- R11: If `start_keep` was set and `cs_rearm` is low, the select stays low after `done`. Otherwise every select is high in the `done` cycle.
- R12: `done` lasts exactly one cycle, and at most one `cs_n` line is low at any time.
- R13: After reset, every `cs_n` is high, and `sclk`, `ena`, `done` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for a timing profile |
| cfg_idx | input | IDX_W | Select index of the profile being written |
| cfg_word | input | CFG_W | Packed profile fields (layout in R1) |
| clk_div | input | DIV_W | Module clocks per serial bit |
| cs_rearm | input | 1 | Release the select after every word |
| start | input | 1 | Request one word |
| start_idx | input | IDX_W | Select index for the requested word |
| start_keep | input | 1 | Keep the select asserted after this word |
| tx_word | input | DATA_W | Word to transmit |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data to the slave |
| cs_n | output | NUM_CS | Active-low chip selects |
| ena | output | 1 | Enable strobe around the data phase |
| busy | output | 1 | Word, window or gap in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_word | output | DATA_W | Received word |

## Verification
A fault in the phase counter or in the max-of-two window selection shows up as a changed number of cycles. The count between the `cs_n` fall and the first SCLK rise changes, or the count of low-SCLK cycles before `done` changes, within the same word. A wrong bit counter or shift register shows at once as an extra or missing SCLK pulse, a wrong parity bit or a wrong `rx_word` at `done`. A wrong select or gap state is seen on the next word: the wrong line goes low, or a new request is accepted before the gap has elapsed.

// File: rtl/spi_cs_timed_master.sv
module spi_cs_timed_master #(
  parameter int NUM_CS = 4,
  parameter int DATA_W = 8,
  parameter int DLY_W  = 8,
  parameter int DIV_W  = 8,
  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int CFG_W = 5 * DLY_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              cs_rearm,
  input  logic              start,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic              start_keep,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [NUM_CS-1:0] cs_n,
  output logic              ena,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_word
);
  localparam int CNT_W = DLY_W + DIV_W + 1;
  localparam int BIT_W = $clog2(DATA_W + 2);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_SHIFT, S_HOLD, S_GAP} state_t;

  state_t            state;
  logic [CFG_W-1:0]  cfg_q [NUM_CS];
  logic [CFG_W-1:0]  act;
  logic [IDX_W-1:0]  cur_idx;
  logic [CNT_W-1:0]  cnt, setup_need, hold_need, on_cyc, off_cyc, gap_need;
  logic [DIV_W-1:0]  div_e, half, pc;
  logic [BIT_W-1:0]  bitn, last_bit;
  logic [DATA_W-1:0] tx_sr, rx_sr;
  logic [NUM_CS-1:0] cs_q;
  logic              par_q, pen_q, keep_q, done_q, pc_end, fin;

  assign act      = cfg_q[(state == S_IDLE) ? start_idx : cur_idx];
  assign div_e    = (clk_div < DIV_W'(2)) ? DIV_W'(2) : clk_div;
  assign half     = div_e >> 1;
  assign on_cyc   = CNT_W'(act[4*DLY_W-1:3*DLY_W]) * CNT_W'(div_e);
  assign off_cyc  = CNT_W'(act[5*DLY_W-1:4*DLY_W]) * CNT_W'(div_e);
  assign gap_need = CNT_W'(act[3*DLY_W-1:2*DLY_W]);

  always_comb begin
    setup_need = act[5*DLY_W] ? '0 : CNT_W'(act[DLY_W-1:0]);
    if (on_cyc > setup_need) setup_need = on_cyc;
    hold_need = act[5*DLY_W] ? '0 : CNT_W'(act[2*DLY_W-1:DLY_W]);
    if (off_cyc > hold_need) hold_need = off_cyc;
  end

  assign pc_end   = (pc == div_e - DIV_W'(1));
  assign last_bit = BIT_W'(DATA_W - 1) + BIT_W'(pen_q);
  assign fin = (state == S_SHIFT && pc_end && bitn == last_bit && hold_need == '0) ||
               (state == S_HOLD && cnt + CNT_W'(1) == hold_need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CS; i++) cfg_q[i] <= '0;
    end else if (cfg_we) begin
      cfg_q[cfg_idx] <= cfg_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      pc      <= '0;
      bitn    <= '0;
      tx_sr   <= '0;
      rx_sr   <= '0;
      par_q   <= 1'b0;
      pen_q   <= 1'b0;
      keep_q  <= 1'b0;
      done_q  <= 1'b0;
      cs_q    <= '1;
      cur_idx <= '0;
    end else begin
      done_q <= 1'b0;
      if (state == S_SHIFT && pc == half && bitn < BIT_W'(DATA_W))
        rx_sr <= {rx_sr[DATA_W-2:0], miso};
      if (fin) begin
        done_q <= 1'b1;
        if (!(keep_q && !cs_rearm)) cs_q <= '1;
        cnt   <= '0;
        state <= (gap_need == '0) ? S_IDLE : S_GAP;
      end else begin
        case (state)
          S_IDLE: if (start) begin
            cur_idx <= start_idx;
            cs_q    <= ~(NUM_CS'(1) << start_idx);
            tx_sr   <= tx_word;
            par_q   <= act[5*DLY_W+2] ? ^tx_word : ~^tx_word;
            pen_q   <= act[5*DLY_W+1];
            keep_q  <= start_keep;
            bitn    <= '0;
            pc      <= '0;
            cnt     <= '0;
            state   <= (setup_need == '0) ? S_SHIFT : S_SETUP;
          end
          S_SETUP: begin
            if (cnt + CNT_W'(1) == setup_need) begin
              cnt   <= '0;
              state <= S_SHIFT;
            end else cnt <= cnt + CNT_W'(1);
          end
          S_SHIFT: begin
            if (pc_end) begin
              pc    <= '0;
              tx_sr <= tx_sr << 1;
              bitn  <= bitn + BIT_W'(1);
              if (bitn == last_bit) begin
                cnt   <= '0;
                state <= S_HOLD;
              end
            end else pc <= pc + DIV_W'(1);
          end
          S_HOLD: cnt <= cnt + CNT_W'(1);
          S_GAP: begin
            if (cnt + CNT_W'(1) == gap_need) state <= S_IDLE;
            else cnt <= cnt + CNT_W'(1);
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (state)
      S_SETUP: ena = (cnt >= on_cyc);
      S_SHIFT: ena = 1'b1;
      S_HOLD:  ena = (cnt < off_cyc);
      default: ena = 1'b0;
    endcase
  end

  assign sclk    = (state == S_SHIFT) && (pc >= half);
  assign mosi    = (state == S_SHIFT) && ((bitn < BIT_W'(DATA_W)) ? tx_sr[DATA_W-1] : par_q);
  assign cs_n    = cs_q;
  assign busy    = (state != S_IDLE);
  assign done    = done_q;
  assign rx_word = rx_sr;
endmodule

module spi_cs_timed_master_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CS-1:0] cs_n,
  input logic              sclk,
  input logic              ena,
  input logic              busy,
  input logic              done
);
  assert_one_select_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_sclk_needs_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !(&cs_n));
  assert_ena_needs_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ena |-> !(&cs_n));
  assert_done_quiet_lines_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!sclk && !ena));
  assert_idle_no_clock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk && !ena));
endmodule

bind spi_cs_timed_master spi_cs_timed_master_chk #(.NUM_CS(NUM_CS)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
  .ena(ena), .busy(busy), .done(done)
);

// File: tb/spi_cs_timed_master_tb_top.sv
module spi_cs_timed_master_tb_top;
  localparam int NCS = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, cs_rearm = 1'b0, start = 1'b0, start_keep = 1'b0, miso = 1'b0;
  logic [1:0]  cfg_idx = '0, start_idx = '0;
  logic [42:0] cfg_word = '0;
  logic [7:0]  clk_div = 8'd2, tx_word = '0;
  logic sclk, mosi, ena, busy, done;
  logic [NCS-1:0] cs_n;
  logic [7:0] rx_word;

  int total = 0, bad = 0, cyc = 0;
  bit ended = 0;
  int m_s[NCS], m_h[NCS], m_g[NCS], m_on[NCS], m_off[NCS];
  bit m_toff[NCS], m_pen[NCS], m_pev[NCS];

  always #2 clk = ~clk;

  spi_cs_timed_master dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_word(cfg_word),
    .clk_div(clk_div), .cs_rearm(cs_rearm), .start(start), .start_idx(start_idx),
    .start_keep(start_keep), .tx_word(tx_word), .miso(miso), .sclk(sclk), .mosi(mosi),
    .cs_n(cs_n), .ena(ena), .busy(busy), .done(done), .rx_word(rx_word)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int deff(input int d);
    return (d < 2) ? 2 : d;
  endfunction

  function automatic int maxi(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !ended) begin
      ended = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic write_cfg(input int idx, input int s, input int h, input int g,
                           input int on, input int off, input bit toff, input bit pen, input bit pev);
    m_s[idx] = s; m_h[idx] = h; m_g[idx] = g; m_on[idx] = on; m_off[idx] = off;
    m_toff[idx] = toff; m_pen[idx] = pen; m_pev[idx] = pev;
    cfg_idx  = 2'(idx);
    cfg_word = {pev, pen, toff, 8'(off), 8'(on), 8'(g), 8'(h), 8'(s)};
    cfg_we   = 1'b1;
    @(posedge clk); @(negedge clk);
    cfg_we   = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (busy && guard < 30000) begin @(negedge clk); guard++; end
  endtask

  // One word; returns at the sample after the done sample.
  task automatic xfer(input int idx, input logic [7:0] data, input logic [7:0] sdata,
                      input bit keep, input bit poke);
    int de, hf, ns, nh, pre, enlo, post, enhi, rises, guard;
    bit prev, others_ok;
    logic [8:0] got, expw;
    logic par;
    de = deff(int'(clk_div)); hf = de / 2;
    ns = maxi(m_toff[idx] ? 0 : m_s[idx], m_on[idx] * de);
    nh = maxi(m_toff[idx] ? 0 : m_h[idx], m_off[idx] * de);
    pre = 0; enlo = 0; post = 0; enhi = 0; rises = 0; guard = 0;
    prev = 0; others_ok = 1; got = '0;
    start_idx = 2'(idx); tx_word = data; start_keep = keep; miso = sdata[7];
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    while (!done && guard < 30000) begin
      if (sclk && !prev) begin
        rises++; got = {got[7:0], mosi}; post = 0; enhi = 0;
      end
      if (!sclk && prev && rises < 8) miso = sdata[7 - rises];
      if (rises == 0 && !sclk) begin pre++; if (!ena) enlo++; end
      if (rises > 0 && !sclk) begin post++; if (ena) enhi++; end
      for (int j = 0; j < NCS; j++) if (j != idx && !cs_n[j]) others_ok = 0;
      // R10: a request mid-word must be ignored
      if (poke && rises == 3) begin start = 1'b1; start_idx = 2'((idx + 1) % NCS); tx_word = ~data; end
      else start = 1'b0;
      prev = sclk;
      @(negedge clk); guard++;
    end
    start = 1'b0;
    par  = m_pev[idx] ? ^data : ~^data;
    expw = m_pen[idx] ? {data, par} : {1'b0, data};
    check(guard < 30000, "R12 done reached", guard, 30000);
    check(pre == ns + hf, "R2 setup to first rise", pre, ns + hf);
    check(post == nh, "R3 hold cycles", post, nh);
    if (m_toff[idx]) check(pre == m_on[idx] * de + hf, "R4 timers disabled", pre, m_on[idx] * de + hf);
    check(enlo == m_on[idx] * de, "R5 ena delay after select", enlo, m_on[idx] * de);
    check(enhi == m_off[idx] * de, "R5 ena hold after data", enhi, m_off[idx] * de);
    check(rises == 8 + int'(m_pen[idx]), "R6 bit count", rises, 8 + int'(m_pen[idx]));
    check(got == expw, "R7 R6 mosi bits", int'(got), int'(expw));
    check(rx_word == sdata, "R7 rx word", int'(rx_word), int'(sdata));
    check(cs_n[idx] == !(keep && !cs_rearm), "R11 select after done", int'(cs_n[idx]), int'(!(keep && !cs_rearm)));
    check(others_ok, "R12 other selects high", int'(others_ok), 1);
    @(negedge clk);
    check(!done, "R12 done one cycle", int'(done), 0);
  endtask

  // Holds start from the sample after done; counts cycles until the select falls.
  task automatic gap_probe(input int idx);
    int cnt, exp, guard;
    cnt = 0; guard = 0;
    exp = (m_g[idx] == 0) ? 1 : m_g[idx];
    start_idx = 2'(idx); tx_word = 8'h5A; start_keep = 1'b0; start = 1'b1;
    while (cs_n[idx] && guard < 2000) begin cnt++; @(negedge clk); guard++; end
    start = 1'b0;
    check(cnt == exp, "R9 R10 gap before next word", cnt, exp);
    guard = 0;
    while (!done && guard < 30000) begin @(negedge clk); guard++; end
    @(negedge clk);
    wait_idle();
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(&cs_n && !sclk && !ena && !done && !busy, "R13 reset outputs",
          int'({cs_n, sclk, ena, done, busy}), int'({4'hF, 4'h0}));
    rst_n = 1'b1;
    @(negedge clk);

    // R1: distinct profiles per select
    write_cfg(0, 3, 2, 4, 0, 0, 0, 0, 0);
    write_cfg(1, 0, 0, 0, 0, 0, 0, 1, 0);
    write_cfg(2, 1, 1, 2, 5, 3, 0, 1, 1);
    write_cfg(3, 9, 7, 3, 1, 1, 1, 0, 0);
    clk_div = 8'd4;
    xfer(0, 8'hA5, 8'h3C, 0, 0); wait_idle();
    xfer(1, 8'h01, 8'hFF, 0, 0); wait_idle();
    xfer(2, 8'hC3, 8'h81, 0, 0); wait_idle();
    xfer(3, 8'h7E, 8'h00, 0, 0); wait_idle();
    // R8: divider below 2 behaves as 2
    clk_div = 8'd1; xfer(1, 8'h96, 8'h69, 0, 0); wait_idle();
    clk_div = 8'd0; xfer(2, 8'h00, 8'hAA, 0, 0); wait_idle();
    // R10: start pulse mid-word is ignored
    clk_div = 8'd3; xfer(0, 8'h5C, 8'hE1, 0, 1); wait_idle();
    check(&cs_n && !busy, "R10 no extra word", int'(cs_n), 15);
    // R9: gap
    xfer(0, 8'h11, 8'h22, 0, 0); gap_probe(0);
    xfer(1, 8'h33, 8'h44, 0, 0); gap_probe(1);
    // R11: keep versus re-arm
    cs_rearm = 1'b0; xfer(2, 8'hF0, 8'h0F, 1, 0); wait_idle();
    check(!cs_n[2], "R11 kept select stays low", int'(cs_n[2]), 0);
    xfer(2, 8'h0F, 8'hF0, 0, 0); wait_idle();
    cs_rearm = 1'b1; xfer(3, 8'hAA, 8'h55, 1, 0); wait_idle();
    check(cs_n[3], "R11 re-arm releases select", int'(cs_n[3]), 1);

    for (int k = 0; k < 24; k++) begin
      int idx;
      idx = int'($urandom_range(0, NCS - 1));
      write_cfg(idx, int'($urandom_range(0, 12)), int'($urandom_range(0, 12)),
                int'($urandom_range(0, 6)), int'($urandom_range(0, 4)),
                int'($urandom_range(0, 4)), bit'($urandom_range(0, 1)),
                bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
      clk_div  = 8'($urandom_range(2, 6));
      cs_rearm = 1'($urandom_range(0, 1));
      xfer(idx, 8'($urandom), 8'($urandom), bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
      wait_idle();
    end
    cs_rearm = 1'b0;
    xfer(0, 8'h3D, 8'hB2, 0, 0); wait_idle();

    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule